// File: doc/BRIEF.md
# Programmable Active-Video Window Generator

This block rebuilds the active-video window of a raster from bare sync pulses. Each HSYNC leading edge restarts a pixel position counter. Each VSYNC leading edge restarts a line counter. Four geometry values place a rectangle of active pixels inside the raster: horizontal delay, line width, vertical delay and screen height. When the force input is high, the generated window drives the display-enable output. When it is low, the incoming enable is forwarded instead. Pixel data is forwarded on both paths with one clock of latency.

Interlaced sources are handled by classifying each VSYNC leading edge. An edge that lands close behind an HSYNC edge starts field 0. An edge that lands later in the line starts field 1. In field 1 the vertical window moves down by a programmable number of lines.

A second 8-bit output can carry a stream with timing reference codes. On every line, a start code is placed just before the active pixels and an end code just after them. Active pixels are clipped away from the reserved code values. Blanking is filled with the standard alternating blank levels. The geometry is captured at each VSYNC leading edge, so a frame never changes shape partway through.

Top module: `dewin_gen`

## Requirements
- R1: While rst_n is low, de_out, pix_out and bt_out are all 0.
- R2: pix_out equals pix_in delayed by exactly one clock.
- R3: When force_de is 0, de_out equals de_in delayed by one clock.
- R4: Position 0 is the clock edge at which hsync_in is first sampled high after being low. The position then counts up by one per clock and holds at 8191, and it is 8191 after reset. When force_de is 1, de_out is high after edges at positions hdelay+1 through hdelay+width. A width of 0 gives no enable.
- R5: A VSYNC leading edge sets the line number to 0, and an HSYNC edge on the same clock is not counted. Each later HSYNC leading edge adds one, and the line number holds at 8191, which is also its value after reset. A field-0 line is inside the vertical window when vdelay < line ≤ vdelay+height. No window or enable occurs before the first VSYNC.
- R6: A VSYNC leading edge at a position below ALIGN_WIN (default 8; 0 when HSYNC rises on the same edge) starts field 0. Any other position starts field 1. In field 1 the vertical window moves down by foffs lines.
- R7: The geometry values vdelay, hdelay, width, height and foffs are captured only on the clock of a VSYNC leading edge. That capture applies from that edge onward. Until the first VSYNC the values are 24, 260, 1280, 720 and 0.
- R8: When bt656_en is 0, bt_out equals pix_in delayed by one clock.
- R9: When bt656_en is 1, every line carries a start code at positions hdelay−3 through hdelay. The code is the words FF, 00, 00, XY with H=0. Words that would fall before position 0 are dropped.
- R10: When bt656_en is 1, every line carries an end code at positions hdelay+width+1 through hdelay+width+4. It is FF, 00, 00, XY with H=1.
- R11: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. F is the current field. V is 1 on lines outside the vertical window.
- R12: When bt656_en is 1, a pixel inside the active window is output clipped to 01..FE. Every other position outputs 80 at even positions and 10 at odd positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| de_in | input | 1 | Incoming display enable |
| pix_in | input | 8 | Incoming pixel data |
| force_de | input | 1 | 1 selects the generated enable |
| bt656_en | input | 1 | 1 inserts timing reference codes on bt_out |
| cfg_vdelay | input | 6 | Lines from VSYNC to first active line |
| cfg_hdelay | input | 10 | Pixels from HSYNC to first active pixel |
| cfg_width | input | 12 | Active pixels per line |
| cfg_height | input | 12 | Active lines per field |
| cfg_foffs | input | 3 | Field-1 vertical shift in lines |
| de_out | output | 1 | Display enable |
| pix_out | output | 8 | Delayed pixel data |
| bt_out | output | 8 | Stream with reference codes |

## Verification
The sweeps probe several failure points.

- Horizontal delays of 0 and 1 put the start code partly before the line start. A design that wraps negative positions would emit stray words late in the line. One that misplaces the edge-0 word would corrupt the XY byte.
- A VSYNC placed at position 7 and at position 8 checks the field split. An off-by-one here flips F and moves the whole field-1 window by the offset.
- The geometry inputs carry junk on every clock except the VSYNC edge. A design that reads them live would shift or resize DE within the frame.
- A long first line checks the reset geometry through the code positions 257 and 1541. Zero width and height are swept to catch windows that wrap or leak.

// File: rtl/dewin_gen.sv
module dewin_gen #(
  parameter int VD_W = 6,
  parameter int HD_W = 10,
  parameter int SZ_W = 12,
  parameter int OF_W = 3,
  parameter int ALIGN_WIN = 8,
  parameter logic [VD_W-1:0] DEF_VDELAY = 24,
  parameter logic [HD_W-1:0] DEF_HDELAY = 260,
  parameter logic [SZ_W-1:0] DEF_WIDTH = 1280,
  parameter logic [SZ_W-1:0] DEF_HEIGHT = 720
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync_in,
  input  logic            vsync_in,
  input  logic            de_in,
  input  logic [7:0]      pix_in,
  input  logic            force_de,
  input  logic            bt656_en,
  input  logic [VD_W-1:0] cfg_vdelay,
  input  logic [HD_W-1:0] cfg_hdelay,
  input  logic [SZ_W-1:0] cfg_width,
  input  logic [SZ_W-1:0] cfg_height,
  input  logic [OF_W-1:0] cfg_foffs,
  output logic            de_out,
  output logic [7:0]      pix_out,
  output logic [7:0]      bt_out
);
  localparam int CNT_W = SZ_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic            hs_q, vs_q, fld_q;
  logic [CNT_W-1:0] hcnt, lcnt;
  logic [VD_W-1:0] vd_q;
  logic [HD_W-1:0] hd_q;
  logic [SZ_W-1:0] w_q, h_q;
  logic [OF_W-1:0] of_q;

  wire hs_rise = hsync_in & ~hs_q;
  wire vs_rise = vsync_in & ~vs_q;

  wire [CNT_W-1:0] hinc = (hcnt == CNT_MAX) ? hcnt : hcnt + 1'b1;
  wire [CNT_W-1:0] linc = (lcnt == CNT_MAX) ? lcnt : lcnt + 1'b1;
  wire [CNT_W-1:0] pos  = hs_rise ? '0 : hinc;
  wire [CNT_W-1:0] lnum = vs_rise ? '0 : (hs_rise ? linc : lcnt);
  wire fld_now = vs_rise ? (pos >= CNT_W'(ALIGN_WIN)) : fld_q;

  wire [VD_W-1:0] vd_e = vs_rise ? cfg_vdelay : vd_q;
  wire [HD_W-1:0] hd_e = vs_rise ? cfg_hdelay : hd_q;
  wire [SZ_W-1:0] w_e  = vs_rise ? cfg_width  : w_q;
  wire [SZ_W-1:0] h_e  = vs_rise ? cfg_height : h_q;
  wire [OF_W-1:0] of_e = vs_rise ? cfg_foffs  : of_q;

  wire [CNT_W-1:0] hd_x  = CNT_W'(hd_e);
  wire [CNT_W-1:0] a_end = hd_x + CNT_W'(w_e);
  wire [CNT_W-1:0] v_lo  = CNT_W'(vd_e) + (fld_now ? CNT_W'(of_e) : '0);

  wire h_act  = (pos > hd_x) && (pos <= a_end);
  wire v_act  = (lnum > v_lo) && (lnum <= v_lo + CNT_W'(h_e));
  wire in_act = h_act & v_act;

  wire sav = (pos + CNT_W'(3) >= hd_x) && (pos <= hd_x);
  wire eav = (pos > a_end) && (pos <= a_end + CNT_W'(4));
  wire [CNT_W-1:0] sav_d = pos + CNT_W'(3) - hd_x;
  wire [CNT_W-1:0] eav_d = pos - a_end - CNT_W'(1);
  wire [1:0] widx = eav ? eav_d[1:0] : sav_d[1:0];

  wire fb = fld_now;
  wire vb = ~v_act;
  wire hb = eav;
  wire [7:0] xy = {1'b1, fb, vb, hb, vb ^ hb, fb ^ hb, fb ^ vb, fb ^ vb ^ hb};
  wire [7:0] word = (widx == 2'd3) ? xy : ((widx == 2'd0) ? 8'hFF : 8'h00);
  wire [7:0] clip = (pix_in == 8'h00) ? 8'h01 : ((pix_in == 8'hFF) ? 8'hFE : pix_in);
  wire [7:0] blank = pos[0] ? 8'h10 : 8'h80;

  logic [7:0] bt_nx;
  always_comb begin
    if (!bt656_en)     bt_nx = pix_in;
    else if (in_act)   bt_nx = clip;
    else if (sav | eav) bt_nx = word;
    else               bt_nx = blank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      fld_q <= 1'b0;
      hcnt <= CNT_MAX;
      lcnt <= CNT_MAX;
      vd_q <= DEF_VDELAY;
      hd_q <= DEF_HDELAY;
      w_q  <= DEF_WIDTH;
      h_q  <= DEF_HEIGHT;
      of_q <= '0;
      de_out  <= 1'b0;
      pix_out <= 8'h00;
      bt_out  <= 8'h00;
    end else begin
      hs_q <= hsync_in;
      vs_q <= vsync_in;
      fld_q <= fld_now;
      hcnt <= pos;
      lcnt <= lnum;
      if (vs_rise) begin
        vd_q <= cfg_vdelay;
        hd_q <= cfg_hdelay;
        w_q  <= cfg_width;
        h_q  <= cfg_height;
        of_q <= cfg_foffs;
      end
      de_out  <= force_de ? in_act : de_in;
      pix_out <= pix_in;
      bt_out  <= bt_nx;
    end
  end
endmodule

// File: rtl/dewin_gen_chk.sv
module dewin_gen_chk #(
  parameter int HD_W = 10,
  parameter int SZ_W = 12
)(
  input logic            clk,
  input logic            rst_n,
  input logic            force_de,
  input logic            bt656_en,
  input logic            de_in,
  input logic [7:0]      pix_in,
  input logic            de_out,
  input logic [7:0]      pix_out,
  input logic [7:0]      bt_out,
  input logic            vs_rise,
  input logic            in_act,
  input logic [HD_W-1:0] hd_q,
  input logic [SZ_W-1:0] w_q
);
  logic f_q;
  logic [SZ_W:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      run <= '0;
    end else begin
      f_q <= force_de;
      if (de_out && f_q && run != '1) run <= run + 1'b1;
      else if (!(de_out && f_q)) run <= '0;
    end
  end

  // R2
  pix_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pix_out == $past(pix_in));
  // R3
  de_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_de |=> de_out == $past(de_in));
  // R8
  bt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bt656_en |=> bt_out == $past(pix_in));
  // R12
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt656_en && in_act) |=> (bt_out != 8'h00 && bt_out != 8'hFF));
  // R9
  code_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_out == 8'hFF && $past(bt656_en) && bt656_en) |=> bt_out == 8'h00);
  // R4
  de_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= {1'b0, w_q});
  // R7
  geom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> ($stable(w_q) && $stable(hd_q)));
endmodule

bind dewin_gen dewin_gen_chk #(.HD_W(HD_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_de(force_de), .bt656_en(bt656_en),
  .de_in(de_in), .pix_in(pix_in), .de_out(de_out), .pix_out(pix_out),
  .bt_out(bt_out), .vs_rise(vs_rise), .in_act(in_act), .hd_q(hd_q), .w_q(w_q)
);

// File: tb/sim_dewin_gen.sv
module sim_dewin_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, hsync_in, vsync_in, de_in, force_de, bt656_en;
  logic [7:0] pix_in;
  logic [5:0] cfg_vdelay;
  logic [9:0] cfg_hdelay;
  logic [11:0] cfg_width, cfg_height;
  logic [2:0] cfg_foffs;
  logic de_out;
  logic [7:0] pix_out, bt_out;

  dewin_gen u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mk = 8191, mn = 8191, mf = 0;
  int s_hd = 260, s_w = 1280, s_h = 720, s_vd = 24, s_of = 0;
  int c_hd, c_w, c_h, c_vd, c_of;
  bit p_hs = 0, p_vs = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic tick(bit hs, bit vs);
    bit vr, hr, hwin, vwin, sv, ev, fb, vb, hb;
    int off, e_de, e_bt, wi, xy;
    string tag;
    vr = vs && !p_vs;
    hr = hs && !p_hs;
    de_in = cyc[2] ^ cyc[0];
    pix_in = 8'(cyc * 37);
    hsync_in = hs;
    vsync_in = vs;
    if (vr) begin
      cfg_vdelay = 6'(c_vd); cfg_hdelay = 10'(c_hd); cfg_width = 12'(c_w);
      cfg_height = 12'(c_h); cfg_foffs = 3'(c_of);
    end else begin
      cfg_vdelay = 6'(cyc * 5 + 3); cfg_hdelay = 10'(cyc * 7 + 1);
      cfg_width = 12'(cyc * 3 + 2); cfg_height = 12'(cyc + 1); cfg_foffs = 3'(cyc + 3);
    end
    if (hr) mk = 0; else if (mk < 8191) mk++;
    if (vr) begin
      mn = 0; mf = (mk >= 8) ? 1 : 0;
      s_hd = c_hd; s_w = c_w; s_h = c_h; s_vd = c_vd; s_of = c_of;
    end else if (hr && mn < 8191) mn++;
    off = mf ? s_of : 0;
    hwin = (mk > s_hd) && (mk <= s_hd + s_w);
    vwin = (mn > s_vd + off) && (mn <= s_vd + off + s_h);
    e_de = force_de ? int'(hwin && vwin) : int'(de_in);
    sv = (mk >= s_hd - 3) && (mk <= s_hd);
    ev = (mk > s_hd + s_w) && (mk <= s_hd + s_w + 4);
    fb = mf[0]; vb = !vwin; hb = ev;
    xy = 128 | (fb << 6) | (vb << 5) | (hb << 4) | ((vb ^ hb) << 3)
       | ((fb ^ hb) << 2) | ((fb ^ vb) << 1) | (fb ^ vb ^ hb);
    if (!bt656_en) begin e_bt = pix_in; tag = "R8"; end
    else if (hwin && vwin) begin
      e_bt = (pix_in == 0) ? 1 : (pix_in == 255) ? 254 : int'(pix_in); tag = "R12";
    end else if (sv || ev) begin
      wi = sv ? mk - (s_hd - 3) : mk - (s_hd + s_w + 1);
      e_bt = (wi == 3) ? xy : (wi == 0) ? 255 : 0;
      tag = (wi == 3) ? "R11" : (sv ? "R9" : "R10");
    end else begin e_bt = mk[0] ? 16 : 128; tag = "R12"; end
    @(posedge clk);
    @(negedge clk);
    chk(pix_out == 8'(cyc * 37), "R2", pix_out, 8'(cyc * 37));
    chk(int'(de_out) == e_de, force_de ? "R4/R5/R6/R7" : "R3", de_out, e_de);
    chk(int'(bt_out) == e_bt, tag, bt_out, e_bt);
    p_hs = hs; p_vs = vs; cyc++;
  endtask

  task automatic frame(int vpos, int nl);
    for (int l = 0; l < nl; l++)
      for (int p = 0; p < 24; p++)
        tick(p < 2, l == 0 && p >= vpos && p < vpos + 3);
  endtask

  initial begin
    int idx, hds[4], ws[3], hs_[3];
    hds = '{0, 1, 3, 6}; ws = '{0, 1, 5}; hs_ = '{0, 1, 3};
    rst_n = 0; hsync_in = 0; vsync_in = 0; de_in = 1; pix_in = 8'hA5;
    force_de = 1; bt656_en = 1;
    cfg_vdelay = 0; cfg_hdelay = 0; cfg_width = 0; cfg_height = 0; cfg_foffs = 0;
    repeat (3) begin
      @(negedge clk);
      // R1 reset state
      chk(de_out == 0 && pix_out == 0 && bt_out == 0, "R1", {de_out, pix_out, bt_out}, 0);
    end
    rst_n = 1;
    // R7 defaults before first VSYNC, codes at 257 and 1541 with V=1
    c_hd = 260; c_w = 1280; c_h = 720; c_vd = 24; c_of = 0;
    repeat (3) tick(0, 0);
    tick(1, 0); tick(1, 0);
    repeat (1600) tick(0, 0);
    idx = 0;
    foreach (hds[a]) foreach (ws[b]) for (int vd = 0; vd < 3; vd += 2)
      foreach (hs_[c]) for (int of = 0; of < 3; of += 2) begin
        c_hd = hds[a]; c_w = ws[b]; c_vd = vd; c_h = hs_[c]; c_of = of;
        force_de = idx[0]; bt656_en = idx[1] | idx[2];
        frame(0, vd + of + hs_[c] + 2);
        // R6 split at position 7 versus 8, plus mid-line
        frame((idx % 3 == 0) ? 7 : (idx % 3 == 1) ? 8 : 10, vd + of + hs_[c] + 2);
        idx++;
      end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule